// File: doc/BRIEF.md
# Receive Byte Queue with Programmable Level Alert

This block holds bytes that a serial bus engine has received until host software collects them. The bus side offers one byte per cycle on a push port. The host takes one byte per read of the receive data register, which is modelled here as a pop strobe. The queue holds 16 bytes by default and returns them in arrival order.

The host programs an alert level. The value is zero-based, so writing N makes the alert assert once N+1 bytes are stored. The alert is a level signal. It is recomputed every cycle from the stored count and the programmed value, so it goes to the interrupt logic without any edge detection. The host reads back a zero-based fill count and a status byte with empty and full flags. It re-arms the level after each drain.

A push that arrives while the queue is full is lost, and a sticky overflow flag records the loss. A synchronous flush input empties the queue and clears that flag. The programmed level survives a flush.

Top module: `rx_byte_queue`

## Requirements
- R1: The queue accepts DEPTH (16) pushes from empty. Once 16 bytes are stored, status bit 5 (full) reads 1, and it reads 0 at any lower count.
- R2: Pops return the pushed bytes in push order. The head byte is visible on `pop_data_o` in the same cycle that `pop_i` is high.
- R3: A push while 16 bytes are stored is dropped and sets `overflow_o`. That flag stays set until a flush or a reset.
- R4: `occ_o` reads the stored count minus one, and reads 0 when the queue is empty. Status bit 6 (empty) reads 1 exactly when no byte is stored. All other status bits read 0.
- R5: A pop on an empty queue yields 0x00 on `pop_data_o` and leaves the stored count and the read order unchanged.
- R6: `wm_o` returns the last level written through `wm_we_i`/`wm_data_i`. `level_hit_o` is 1 exactly when the stored count is at least that value plus one.
- R7: `level_hit_o` follows a level rewrite in the cycle after the write. Writing a level below the current fill asserts it at once, with no push needed.
- R8: A flush empties the queue and clears `overflow_o` on the next edge. It leaves the programmed level unchanged.
- R9: Each accepted pop removes exactly one byte, so `occ_o` falls by one when the queue holds more than one byte.
- R10: After reset the queue is empty, `overflow_o` and `level_hit_o` read 0, and the level reads DEPTH-1 (15).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous queue flush |
| push_i | input | 1 | Bus side offers a byte |
| push_data_i | input | DATA_W | Byte offered by the bus side |
| pop_i | input | 1 | Host reads the receive data register |
| pop_data_o | output | DATA_W | Head byte, or 0x00 when empty |
| wm_we_i | input | 1 | Host writes the level register |
| wm_data_i | input | PTR_W | Zero-based level value |
| wm_o | output | PTR_W | Level register readback |
| occ_o | output | PTR_W | Zero-based fill count |
| status_o | output | 8 | Bit 6 empty, bit 5 full, all other bits zero |
| overflow_o | output | 1 | Sticky flag for dropped pushes |
| level_hit_o | output | 1 | Fill has reached the programmed level |

## Verification
The hardest state to reach from the ports is a full queue that has also overflowed, with the alert level set somewhere in the middle. In that state the full flag, the sticky overflow flag and the level comparison must all hold at once while pops drain the queue. The bench reaches it by sweeping every level value from 0 to 15. For each value it flushes, then pushes 17 bytes so that the last push is always dropped, then pops all of them. After every step it checks the count, the flags, the alert and the byte order. A separate sequence fills part of the queue and then rewrites the level below, at, and just above the current fill. This exercises the immediate re-evaluation of the alert.

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  input  logic              wm_we_i,
  input  logic [PTR_W-1:0]  wm_data_i,
  output logic [PTR_W-1:0]  wm_o,
  output logic [PTR_W-1:0]  occ_o,
  output logic [7:0]        status_o,
  output logic              overflow_o,
  output logic              level_hit_o
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr, wm_q;
  logic [CNT_W-1:0]  count;
  logic              ovf_q;

  logic is_empty, is_full, push_ok, pop_ok;

  assign is_empty = (count == '0);
  assign is_full  = (count == CNT_W'(DEPTH));
  assign push_ok  = push_i && !is_full;
  assign pop_ok   = pop_i && !is_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf_q  <= 1'b0;
      wm_q   <= PTR_W'(DEPTH - 1);
    end else begin
      if (wm_we_i) wm_q <= wm_data_i;
      if (flush_i) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        count  <= '0;
        ovf_q  <= 1'b0;
      end else begin
        if (push_ok) wr_ptr <= wr_ptr + 1'b1;
        if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
        count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        if (push_i && is_full) ovf_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush_i) mem[wr_ptr] <= push_data_i;
  end

  assign pop_data_o  = is_empty ? '0 : mem[rd_ptr];
  assign wm_o        = wm_q;
  assign occ_o       = is_empty ? '0 : PTR_W'(count - 1'b1);
  assign status_o    = {1'b0, is_empty, is_full, 5'b0};
  assign overflow_o  = ovf_q;
  assign level_hit_o = (count > {1'b0, wm_q});

endmodule

module rx_byte_queue_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_i,
  input logic              push_i,
  input logic [DATA_W-1:0] push_data_i,
  input logic              pop_i,
  input logic [DATA_W-1:0] pop_data_o,
  input logic              wm_we_i,
  input logic [PTR_W-1:0]  wm_data_i,
  input logic [PTR_W-1:0]  wm_o,
  input logic [PTR_W-1:0]  occ_o,
  input logic [7:0]        status_o,
  input logic              overflow_o,
  input logic              level_hit_o
);

  assert_full_occ_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[5] |-> (occ_o == PTR_W'(DEPTH - 1)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[5] && push_i && !flush_i) |=> overflow_o);

  assert_sticky_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !flush_i) |=> overflow_o);

  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[6] && pop_i) |-> (pop_data_o == '0));

  assert_empty_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[6] && pop_i && !push_i) |=> status_o[6]);

  assert_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    level_hit_o == (!status_o[6] && occ_o >= wm_o));

  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (status_o[6] && !overflow_o));

  assert_one_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !flush_i && occ_o != '0) |=>
      (occ_o == $past(occ_o) - PTR_W'(1)));

endmodule

bind rx_byte_queue rx_byte_queue_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/rx_byte_queue_bench.sv
module rx_byte_queue_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int LIMIT = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush_i = 1'b0, push_i = 1'b0, pop_i = 1'b0, wm_we_i = 1'b0;
  logic [7:0] push_data_i = '0;
  logic [3:0] wm_data_i = '0;
  logic [7:0] pop_data_o, status_o;
  logic [3:0] wm_o, occ_o;
  logic       overflow_o, level_hit_o;

  int checks = 0, fails = 0, cyc = 0;

  rx_byte_queue u_rx_byte_queue (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int w, int i);
    return 8'((w * 16 + i) * 37 + 5);
  endfunction

  task automatic check_state(int n, int wm, bit ovf);
    check("R4 occ", occ_o, (n == 0) ? 0 : n - 1);
    check("R4 empty", status_o[6], n == 0);
    check("R1 full", status_o[5], n == DEPTH);
    check("R4 other status bits", {status_o[7], status_o[4:0]}, 0);
    check("R6 level", level_hit_o, n >= wm + 1);
    check("R3 overflow", overflow_o, ovf);
  endtask

  task automatic do_push(logic [7:0] d);
    @(negedge clk); push_i = 1'b1; push_data_i = d;
    @(negedge clk); push_i = 1'b0;
  endtask

  task automatic do_pop(string tag, int exp);
    @(negedge clk); pop_i = 1'b1; #1;
    check(tag, pop_data_o, exp);
    @(negedge clk); pop_i = 1'b0;
  endtask

  task automatic set_wm(int w);
    @(negedge clk); wm_we_i = 1'b1; wm_data_i = 4'(w);
    @(negedge clk); wm_we_i = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush_i = 1'b1;
    @(negedge clk); flush_i = 1'b0;
  endtask

  initial begin
    wait (cyc == LIMIT);
    fails++;
    $display("FAIL watchdog act=%0d exp=<%0d", cyc, LIMIT);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 wm reset", wm_o, 15);
    check_state(0, 15, 0);

    // Sweep over every level: fill past capacity, then drain
    for (int w = 0; w < DEPTH; w++) begin
      set_wm(w);
      check("R6 wm readback", wm_o, w);
      do_flush();
      check("R8 wm kept", wm_o, w);
      check_state(0, w, 0);
      for (int k = 1; k <= DEPTH + 1; k++) begin
        do_push(pat(w, k - 1));
        check_state((k > DEPTH) ? DEPTH : k, w, k > DEPTH);
      end
      for (int j = 0; j < DEPTH; j++) begin
        do_pop("R2 order", pat(w, j));
        check_state(DEPTH - 1 - j, w, 1);   // R9 one byte per pop, R3 sticky
      end
    end

    // R5 pop on empty returns zero and keeps order
    do_flush();
    check_state(0, 15, 0);
    do_pop("R5 empty data", 0);
    check_state(0, 15, 0);
    do_push(8'hA5);
    do_pop("R5 order kept", 8'hA5);
    check_state(0, 15, 0);

    // R7 level rewrite below/at/above current fill
    for (int i = 0; i < 5; i++) do_push(8'(i));
    check("R7 level before", level_hit_o, 0);
    set_wm(2);
    check("R7 level below fill", level_hit_o, 1);
    set_wm(4);
    check("R7 level at fill", level_hit_o, 1);
    set_wm(5);
    check("R7 level above fill", level_hit_o, 0);

    // R8 flush after overflow clears it, level kept
    for (int i = 0; i < 12; i++) do_push(8'(i));
    check("R3 overflow set", overflow_o, 1);
    do_flush();
    check("R8 flush ovf", overflow_o, 0);
    check("R8 flush empty", status_o[6], 1);
    check("R8 flush wm", wm_o, 5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule